// File: doc/BRIEF.md
# Cosine Similarity Streaming Element

This block scores a stream of target records against one stored source record by cosine similarity. Every record is 200 signed 16-bit words. Index 0 to 197 carry the property vector, index 198 carries the precomputed magnitude (the root of the sum of squares), and index 199 carries the item identifier. Software writes the source record once through a simple write port. Target records then arrive one word per clock on a valid/ready stream. The last word of each record is marked.

For every well-formed target, the block accumulates the dot product of the two vectors at full width. It then divides that dot product by the product of the two stored magnitudes and emits the item identifier with a signed Q1.15 score. A +1.0 score means the vectors point the same way and -1.0 means they point opposite ways. The division is serial and runs while the next record is accumulating, so a continuous input stream never sees a bubble as long as results are consumed. No square root is computed in hardware because both magnitudes arrive precomputed. Ranking the scores is left to a later stage.

Top module: `cos_sim_stream`

## Requirements
- R1: Target word index 0..197 is a vector element, index 198 is the magnitude and index 199 is the ID; `out_id` equals the index-199 word of the record it belongs to.
- R2: `out_score` equals trunc_toward_zero(dot × 32768 / (src_mag × tgt_mag)) as a signed 16-bit two's-complement Q1.15 value, where dot is the exact sum over index 0..197 of source × target.
- R3: The score magnitude saturates at 32767, so the result stays in [-32767, +32767] even when the supplied magnitudes understate the vectors.
- R4: Source (3,4,0,…) with magnitude 5 against target (5,12,0,…) with magnitude 13 gives 31759 (≈0.969); source (3,-4,0,…) gives -16636 (≈-0.508).
- R5: A source written once (vector at write address 0..197, magnitude at 198; address 199 is ignored) is used unchanged for every following target.
- R6: With `out_ready` held high, `in_ready` stays high across any number of back-to-back records, one word accepted per cycle.
- R7: A source or target magnitude that is zero or negative gives score 0 with `out_zero_mag` = 1; otherwise `out_zero_mag` = 0.
- R8: The dot product never overflows. 198 products of -32768 × -32768 accumulate to +198·2^30, which scores +32767 against magnitudes of 32767.
- R9: Exactly one result leaves per well-formed record, in arrival order. While `out_valid` is high and `out_ready` is low, the result holds steady and `in_ready` eventually drops instead of losing data.
- R10: A word with `in_last` = 1 at any index other than 199, or a word at index 199 with `in_last` = 0, raises `frame_err` for one cycle in the cycle after acceptance. It discards the partial record with no result, and the next word is taken as index 0.
- R11: After reset `out_valid` = 0, `frame_err` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_wr_en | input | 1 | Source record write strobe |
| src_wr_addr | input | 8 | Source word index (0..198 stored) |
| src_wr_data | input | 16 | Source word, signed |
| in_valid | input | 1 | Target word valid |
| in_ready | output | 1 | Target word accepted when high with in_valid |
| in_data | input | 16 | Target word, signed |
| in_last | input | 1 | Marks the last word of a target record |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_id | output | 16 | Target ID of the result |
| out_score | output | 16 | Signed Q1.15 similarity score |
| out_zero_mag | output | 1 | A magnitude was zero or negative; score forced to 0 |
| frame_err | output | 1 | One-cycle pulse on a malformed record end |

## Verification
The hardest situation to reach is the full backpressure chain. In it, a finished quotient waits at the output, a second completed record sits in the hand-off register, and a third record is stalled mid-stream. The bench reaches it by holding `out_ready` low while sending three records back to back, then releasing it, and checks that all three results leave in order with none lost. Framing faults are driven as short records ending early and as full-length records missing their end mark. Accumulator overflow is provoked with every element at the most negative code.

// File: rtl/cos_sim_pkg.sv
package cos_sim_pkg;
    parameter int ELEM_W  = 16;
    parameter int VEC_LEN = 198;
    parameter int FRAC_W  = 15;

    localparam int REC_LEN   = VEC_LEN + 2;
    localparam int IDX_W     = $clog2(REC_LEN);
    localparam int MAG_IDX   = VEC_LEN;
    localparam int ID_IDX    = VEC_LEN + 1;
    localparam int PROD_W    = 2 * ELEM_W;
    localparam int ACC_W     = PROD_W + $clog2(VEC_LEN);
    localparam int DEN_W     = PROD_W;
    localparam int NUM_W     = ACC_W + FRAC_W;
    localparam int CNT_W     = $clog2(NUM_W + 1);
    localparam int SCORE_W   = FRAC_W + 1;
    localparam int SCORE_MAX = (2 ** FRAC_W) - 1;

    typedef logic signed [ELEM_W-1:0]  elem_t;
    typedef logic signed [PROD_W-1:0]  prod_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic [IDX_W-1:0]          idx_t;
    typedef logic signed [SCORE_W-1:0] score_t;

    localparam idx_t MAG_IDX_T = idx_t'(MAG_IDX);
    localparam idx_t ID_IDX_T  = idx_t'(ID_IDX);

    // one accepted target word as seen by the accumulator
    typedef struct packed {
        logic  fire;
        logic  rec_done;
        idx_t  idx;
        elem_t data;
    } beat_t;

    // completed record handed to the divider
    typedef struct packed {
        acc_t  dot;
        elem_t smag;
        elem_t tmag;
        elem_t id;
    } job_t;

    typedef enum logic [1:0] {DIV_IDLE, DIV_RUN, DIV_DONE} div_state_e;

    function automatic logic [ACC_W-1:0] acc_abs(input acc_t v);
        logic [ACC_W-1:0] r;
        r = v;
        if (v[ACC_W-1]) r = ~r + 1'b1;
        return r;
    endfunction

    function automatic logic mag_ok(input elem_t m);
        return !m[ELEM_W-1] && (m != elem_t'(0));
    endfunction
endpackage

// File: rtl/cos_src_store.sv
module cos_src_store
    import cos_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_addr,
    input  elem_t wr_data,
    input  idx_t  rd_idx,
    output elem_t rd_elem,
    output elem_t smag
);
    elem_t mem [VEC_LEN];
    elem_t smag_q;

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < MAG_IDX_T)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smag_q <= '0;
        end else if (wr_en && (wr_addr == MAG_IDX_T)) begin
            smag_q <= wr_data;
        end
    end

    assign rd_elem = (rd_idx < MAG_IDX_T) ? mem[rd_idx] : '0;
    assign smag    = smag_q;
endmodule

// File: rtl/cos_framer.sv
module cos_framer
    import cos_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_ready,
    input  logic  in_last,
    input  elem_t in_data,
    output beat_t beat,
    output logic  frame_err
);
    idx_t idx_q;
    logic err_q;
    logic fire;
    logic at_end;
    logic bad_end;

    assign fire    = in_valid && in_ready;
    assign at_end  = (idx_q == ID_IDX_T);
    assign bad_end = fire && (in_last != at_end);

    always_comb begin
        beat.fire     = fire;
        beat.rec_done = fire && in_last && at_end;
        beat.idx      = idx_q;
        beat.data     = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= bad_end;
            if (fire) begin
                if (in_last || at_end) idx_q <= '0;
                else                   idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign frame_err = err_q;

    p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
        idx_q <= ID_IDX_T);

    p_early_last_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && in_last && !at_end) |=> (frame_err && idx_q == '0));
endmodule

// File: rtl/cos_dot_acc.sv
module cos_dot_acc
    import cos_sim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  elem_t src_elem,
    input  elem_t smag,
    input  logic  job_take,
    output logic  job_valid,
    output job_t  job
);
    acc_t  acc_q;
    elem_t tmag_q;
    prod_t prod;
    acc_t  prod_ext;
    logic  job_valid_q;
    job_t  job_q;

    assign prod     = beat.data * src_elem;
    assign prod_ext = acc_t'(prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tmag_q <= '0;
        end else if (beat.fire) begin
            if (beat.idx < MAG_IDX_T) begin
                acc_q <= ((beat.idx == '0) ? acc_t'(0) : acc_q) + prod_ext;
            end else if (beat.idx == MAG_IDX_T) begin
                tmag_q <= beat.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_valid_q <= 1'b0;
            job_q       <= '0;
        end else if (beat.rec_done) begin
            job_valid_q <= 1'b1;
            job_q.dot   <= acc_q;
            job_q.smag  <= smag;
            job_q.tmag  <= tmag_q;
            job_q.id    <= beat.data;
        end else if (job_take) begin
            job_valid_q <= 1'b0;
        end
    end

    assign job_valid = job_valid_q;
    assign job       = job_q;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (beat.fire && beat.idx != '0 && beat.idx < MAG_IDX_T &&
         acc_q[ACC_W-1] == prod[PROD_W-1])
        |=> (acc_q[ACC_W-1] == $past(acc_q[ACC_W-1])));

    p_job_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (job_valid && !job_take) |=> (job_valid && $stable(job)));
endmodule

// File: rtl/cos_divider.sv
module cos_divider
    import cos_sim_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   job_valid,
    input  job_t   job,
    output logic   job_take,
    output logic   res_valid,
    input  logic   res_ready,
    output elem_t  res_id,
    output score_t res_score,
    output logic   res_zero
);
    div_state_e       state_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_q;
    logic             zero_q;
    elem_t            id_q;

    logic [DEN_W:0]   rem_sh;
    logic             ge;
    logic [DEN_W-1:0] den_next;
    logic [NUM_W-FRAC_W-1:0] upper;
    score_t           sat_mag;

    assign job_take = (state_q == DIV_IDLE) && job_valid;
    assign den_next = {{ELEM_W{1'b0}}, job.smag} * {{ELEM_W{1'b0}}, job.tmag};
    assign rem_sh   = {rem_q, num_q[NUM_W-1]};
    assign ge       = (rem_sh >= {1'b0, den_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            num_q   <= '0;
            den_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            neg_q   <= 1'b0;
            zero_q  <= 1'b0;
            id_q    <= '0;
        end else begin
            case (state_q)
                DIV_IDLE: begin
                    if (job_valid) begin
                        id_q  <= job.id;
                        rem_q <= '0;
                        if (mag_ok(job.smag) && mag_ok(job.tmag)) begin
                            zero_q  <= 1'b0;
                            neg_q   <= job.dot[ACC_W-1];
                            num_q   <= {acc_abs(job.dot), {FRAC_W{1'b0}}};
                            den_q   <= den_next;
                            cnt_q   <= CNT_W'(NUM_W);
                            state_q <= DIV_RUN;
                        end else begin
                            zero_q  <= 1'b1;
                            neg_q   <= 1'b0;
                            num_q   <= '0;
                            state_q <= DIV_DONE;
                        end
                    end
                end
                DIV_RUN: begin
                    rem_q <= ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
                    num_q <= {num_q[NUM_W-2:0], ge};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_q <= DIV_DONE;
                end
                DIV_DONE: begin
                    if (res_ready) state_q <= DIV_IDLE;
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    assign upper     = num_q[NUM_W-1:FRAC_W];
    assign sat_mag   = (|upper) ? score_t'(SCORE_MAX) : score_t'({1'b0, num_q[FRAC_W-1:0]});
    assign res_score = neg_q ? -sat_mag : sat_mag;
    assign res_valid = (state_q == DIV_DONE);
    assign res_id    = id_q;
    assign res_zero  = zero_q;

    p_score_range_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_score != {1'b1, {FRAC_W{1'b0}}}));

    p_zero_score_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_zero) |-> (res_score == '0));

    p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
        (res_valid && $stable(res_score) && $stable(res_id) && $stable(res_zero)));
endmodule

// File: rtl/cos_sim_stream.sv
module cos_sim_stream
    import cos_sim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_wr_en,
    input  logic [IDX_W-1:0]   src_wr_addr,
    input  logic [ELEM_W-1:0]  src_wr_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ELEM_W-1:0]  in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ELEM_W-1:0]  out_id,
    output logic [SCORE_W-1:0] out_score,
    output logic               out_zero_mag,
    output logic               frame_err
);
    beat_t  beat;
    elem_t  src_elem;
    elem_t  smag;
    logic   job_valid;
    logic   job_take;
    job_t   job;
    elem_t  res_id;
    score_t res_score;

    // a completed record may land only when the hand-off slot is free or draining
    assign in_ready = !job_valid || job_take;

    cos_src_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (src_wr_en),
        .wr_addr (src_wr_addr),
        .wr_data (src_wr_data),
        .rd_idx  (beat.idx),
        .rd_elem (src_elem),
        .smag    (smag)
    );

    cos_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_last   (in_last),
        .in_data   (in_data),
        .beat      (beat),
        .frame_err (frame_err)
    );

    cos_dot_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .src_elem  (src_elem),
        .smag      (smag),
        .job_take  (job_take),
        .job_valid (job_valid),
        .job       (job)
    );

    cos_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .job_valid (job_valid),
        .job       (job),
        .job_take  (job_take),
        .res_valid (out_valid),
        .res_ready (out_ready),
        .res_id    (res_id),
        .res_score (res_score),
        .res_zero  (out_zero_mag)
    );

    assign out_id    = res_id;
    assign out_score = res_score;

    p_slot_free_r6: assert property (@(posedge clk) disable iff (rst)
        (!job_valid) |-> in_ready);
endmodule

// File: tb/cos_sim_stream_tb.sv
module cos_sim_stream_tb;
    import cos_sim_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_wr_en = 1'b0;
    logic [IDX_W-1:0] src_wr_addr = '0;
    logic [ELEM_W-1:0] src_wr_data = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [ELEM_W-1:0] in_data = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [ELEM_W-1:0] out_id;
    logic [SCORE_W-1:0] out_score;
    logic out_zero_mag;
    logic frame_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_sim_stream u_dut (
        .clk(clk), .rst(rst),
        .src_wr_en(src_wr_en), .src_wr_addr(src_wr_addr), .src_wr_data(src_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
        .out_score(out_score), .out_zero_mag(out_zero_mag), .frame_err(frame_err)
    );

    typedef struct {
        int    id;
        int    score;
        bit    zero;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   stall_cnt = 0;
    int   ferr_cnt  = 0;
    int   rdy_mode  = 0;   // 0: always ready, 1: random, 2: held low
    int   sv[VEC_LEN];
    int   tv[VEC_LEN];
    int   src_mag = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int isqrt_ceil(input longint s);
        int r = 0;
        while (longint'(r) * r < s) r++;
        return r;
    endfunction

    function automatic int ref_score(input int sm, input int tm, output bit z);
        longint dot = 0;
        longint num;
        longint q;
        for (int i = 0; i < VEC_LEN; i++) dot += longint'(sv[i]) * tv[i];
        if (sm <= 0 || tm <= 0) begin
            z = 1;
            return 0;
        end
        z = 0;
        num = (dot < 0 ? -dot : dot) * 32768;
        q = num / (longint'(sm) * tm);
        if (q > 32767) q = 32767;
        return (dot < 0) ? -int'(q) : int'(q);
    endfunction

    // out_ready changes a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        case (rdy_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= ($urandom % 4) != 0;
            default: out_ready <= 1'b0;
        endcase
    end

    // result monitor: R1 id, R2/R3/R4 score, R7 flag, R9 order and count
    always @(negedge clk) begin
        if (!rst && frame_err) ferr_cnt++;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected result", longint'(out_id), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(out_id) == (e.id & 16'hFFFF), "R1 id", out_id, e.id & 16'hFFFF);
                check(int'($signed(out_score)) == e.score, e.req,
                      int'($signed(out_score)), e.score);
                check(out_zero_mag == e.zero, "R7 flag", out_zero_mag, e.zero);
            end
        end
    end

    task automatic write_src(input int addr, input int data);
        @(negedge clk);
        src_wr_en   = 1'b1;
        src_wr_addr = IDX_W'(addr);
        src_wr_data = ELEM_W'(data);
        @(posedge clk);
        @(negedge clk);
        src_wr_en = 1'b0;
    endtask

    task automatic load_src(input int mag);
        for (int i = 0; i < VEC_LEN; i++) write_src(i, sv[i]);
        write_src(MAG_IDX, mag);
        src_mag = mag;
    endtask

    task automatic send_beat(input int d, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = ELEM_W'(d);
        in_last  = last;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_rec(input int mag, input int id, input string req);
        exp_t e;
        bit z;
        e.id    = id;
        e.score = ref_score(src_mag, mag, z);
        e.zero  = z;
        e.req   = req;
        exp_q.push_back(e);
        for (int i = 0; i < VEC_LEN; i++) send_beat(tv[i], 1'b0);
        send_beat(mag, 1'b0);
        send_beat(id, 1'b1);
    endtask

    task automatic send_exact(input int mag, input int id, input int score, input string req);
        exp_t e;
        e.id = id; e.score = score; e.zero = 0; e.req = req;
        exp_q.push_back(e);
        for (int i = 0; i < VEC_LEN; i++) send_beat(tv[i], 1'b0);
        send_beat(mag, 1'b0);
        send_beat(id, 1'b1);
    endtask

    task automatic rand_src();
        longint s = 0;
        for (int i = 0; i < VEC_LEN; i++) begin
            sv[i] = int'($urandom % 201) - 100;
            s += longint'(sv[i]) * sv[i];
        end
        load_src(isqrt_ceil(s));
    endtask

    function automatic int rand_tgt();
        longint s = 0;
        for (int i = 0; i < VEC_LEN; i++) begin
            tv[i] = int'($urandom % 2001) - 1000;
            s += longint'(tv[i]) * tv[i];
        end
        return isqrt_ceil(s);
    endfunction

    task automatic drain();
        int n = 0;
        idle_in();
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int m;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        check(frame_err == 1'b0, "R11 frame_err", frame_err, 0);
        check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

        // R4 worked examples
        for (int i = 0; i < VEC_LEN; i++) begin sv[i] = 0; tv[i] = 0; end
        sv[0] = 3; sv[1] = 4; load_src(5);
        tv[0] = 5; tv[1] = 12;
        send_exact(13, 101, 31759, "R4 positive example");
        drain();
        sv[1] = -4; load_src(5);
        send_exact(13, 102, -16636, "R4 negative example");
        drain();

        // R5 one source, many targets; R2 general score; R6 no bubbles
        rand_src();
        stall_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            m = rand_tgt();
            send_rec(m, 1000 + k, "R2 R5 random score");
        end
        check(stall_cnt == 0, "R6 stalls in back-to-back burst", stall_cnt, 0);
        drain();

        // random consumer readiness
        rdy_mode = 1;
        for (int k = 0; k < 8; k++) begin
            m = rand_tgt();
            send_rec(m + int'($urandom % 3), 2000 + k, "R2 random ready");
        end
        drain();
        rdy_mode = 0;

        // R9 backpressure through the whole chain
        stall_cnt = 0;
        rdy_mode = 2;
        fork
            begin
                for (int k = 0; k < 3; k++) begin
                    m = rand_tgt();
                    send_rec(m, 3000 + k, "R9 backpressure order");
                end
            end
            begin
                repeat (700) @(posedge clk);
                rdy_mode = 0;
            end
        join
        check(stall_cnt > 0, "R9 in_ready dropped under backpressure", stall_cnt, 1);
        drain();

        // R7 non-positive magnitudes
        m = rand_tgt();
        send_rec(0, 4000, "R7 zero target magnitude");
        send_rec(-5, 4001, "R7 negative target magnitude");
        drain();
        rand_src();
        write_src(MAG_IDX, 0); src_mag = 0;
        send_rec(m, 4002, "R7 zero source magnitude");
        drain();

        // R8 overflow-free accumulation, R3 positive saturation
        for (int i = 0; i < VEC_LEN; i++) begin sv[i] = -32768; tv[i] = -32768; end
        load_src(32767);
        send_exact(32767, 5000, 32767, "R8 full-scale accumulation");
        drain();
        // R3 negative saturation with understated magnitudes
        for (int i = 0; i < VEC_LEN; i++) begin sv[i] = 100; tv[i] = -100; end
        load_src(1);
        send_exact(1, 5001, -32767, "R3 negative clamp");
        drain();

        // R10 framing errors
        rand_src();
        ferr_cnt = 0;
        for (int i = 0; i < 50; i++) send_beat(int'($urandom % 50), 1'b0);
        send_beat(7, 1'b1);
        idle_in();
        @(negedge clk);
        check(ferr_cnt == 1, "R10 early last flagged", ferr_cnt, 1);
        for (int i = 0; i < REC_LEN; i++) send_beat(int'($urandom % 50), 1'b0);
        idle_in();
        @(negedge clk);
        check(ferr_cnt == 2, "R10 missing last flagged", ferr_cnt, 2);
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0 && !out_valid, "R10 no result for bad records", out_valid, 0);
        m = rand_tgt();
        send_rec(m, 6000, "R10 record after framing errors");
        drain();
        check(ferr_cnt == 2, "R10 no flag on good record", ferr_cnt, 2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule